// File: doc/BRIEF.md
# Character Base Register and Character-Data Fetch Address Generator

This block holds the character-set base of a text-mode video fetch engine and turns each fetched character code into the address of its glyph row. The CPU loads the base through a simple register-write interface. The engine reports each character-name fetch by presenting the fetched byte together with the current scanline row. Exactly three cycles later the block issues the matching character-data fetch. The address for that fetch is the base in the top bits, the character code in the middle bits and the row in the bottom bits.

Both paths are deliberately pipelined. A CPU write first passes through an internal data latch and then a half-cycle write strobe. Only after that does it reach the base register. The fetch address is assembled internally in the issue cycle and appears on the registered address outputs one cycle later. These delays define a last cycle on which a new base still reaches a given fetch. A write one cycle later than that lands too late, and the fetch uses the previous base.

Top module: `chbase_fetch`

## Requirements
- R1: Synchronous active-high reset clears the base to zero and drives `fetch_vld` low and `fetch_addr` to zero.
- R2: A name fetch presented with `name_vld` high in cycle K produces `fetch_vld` high in cycle K+4 (issued in K+3, registered to the outputs at the end of K+3), and `fetch_vld` is never high without such a name fetch.
- R3: When `fetch_vld` is high, `fetch_addr[15:10]` equals base bits 7:2, `fetch_addr[9:3]` equals `name_code[6:0]` and `fetch_addr[2:0]` equals `row`, all captured with the name fetch.
- R4: Bit 7 of `name_code` has no effect on the address.
- R5: The base is loaded only in a cycle with both `wr_en` and `wr_sel` high; `wr_en` alone leaves the base unchanged.
- R6: A write in cycle N is used by every data fetch issued in cycle N+2 or later, which means a name fetch in cycle N-1 or later (its output in cycle N+3 or later).
- R7: A write in the cycle just before a data fetch is issued, which is two cycles after its name fetch, is too late, and that fetch uses the previous base. Example: with base 0x60, a write of 0x80 in that cycle leaves the fetch at base 0x60. A write of 0xA0 one cycle earlier is used.
- R8: While `fetch_vld` is low, `fetch_addr` keeps the last issued address.
- R9: Name fetches in consecutive cycles produce data fetches in consecutive cycles, each with its own code and row.
- R10: A reset cancels every pending data fetch, so no `fetch_vld` appears for name fetches made before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write cycle |
| wr_sel | input | 1 | Write address matches the base register |
| wr_data | input | 8 | CPU write data |
| name_vld | input | 1 | A character-name fetch completes this cycle |
| name_code | input | 8 | Fetched character byte |
| row | input | 3 | Scanline row within the character |
| fetch_vld | output | 1 | Character-data fetch address is valid |
| fetch_addr | output | 16 | Character-data fetch address |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit write data, a 7-bit code, a 3-bit row and a three-cycle name-to-data spacing. This keeps the whole write latency and the issue gap inside a short eight-entry history. As a result, writes landing one and two cycles before an issue, writes every cycle, and name fetches every cycle all occur often in the random phase. Directed sequences cover the late and in-time write pair around base 0x60, a write without the register select, and a reset while three fetches are still pending.

// File: rtl/chb_pkg.sv
package chb_pkg;

    localparam int unsigned CHB_ADDR_W = 16;
    localparam int unsigned CHB_DATA_W = 8;
    localparam int unsigned CHB_CODE_W = 7;
    localparam int unsigned CHB_ROW_W  = 3;
    localparam int unsigned CHB_GAP    = 3;

    typedef enum logic {
        STB_IDLE = 1'b0,
        STB_LOAD = 1'b1
    } strobe_e;

    function automatic int unsigned chb_base_w(input int unsigned aw,
                                               input int unsigned cw,
                                               input int unsigned rw);
        return aw - cw - rw;
    endfunction

    function automatic int unsigned chb_out_lat(input int unsigned gap);
        return gap + 1;
    endfunction

endpackage

// File: rtl/chb_wr_pipe.sv
module chb_wr_pipe
    import chb_pkg::*;
#(
    parameter int unsigned DATA_W = CHB_DATA_W,
    parameter int unsigned BASE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [BASE_W-1:0] base_q
);

    logic [DATA_W-1:0] latch_q;
    strobe_e           strobe_q;
    logic              hit;

    assign hit = wr_en && wr_sel;

    // stage 1: internal data latch; stage 2: strobed load of the base
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q  <= '0;
            strobe_q <= STB_IDLE;
            base_q   <= '0;
        end else begin
            strobe_q <= hit ? STB_LOAD : STB_IDLE;
            if (hit) begin
                latch_q <= wr_data;
            end
            if (strobe_q == STB_LOAD) begin
                base_q <= latch_q[DATA_W-1 -: BASE_W];
            end
        end
    end

    a_r5_no_write_unselected: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en && wr_sel, 2) && !$past(rst) && !$past(rst, 2)) |-> $stable(base_q));

    a_r6_base_after_two: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en && wr_sel, 2) && !$past(rst) && !$past(rst, 2))
            |-> (base_q == $past(wr_data[DATA_W-1 -: BASE_W], 2)));

endmodule

// File: rtl/chb_fetch_delay.sv
module chb_fetch_delay
    import chb_pkg::*;
#(
    parameter int unsigned CODE_W = CHB_CODE_W,
    parameter int unsigned ROW_W  = CHB_ROW_W,
    parameter int unsigned GAP    = CHB_GAP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              name_vld,
    input  logic [CODE_W-1:0] name_code,
    input  logic [ROW_W-1:0]  row,
    output logic              iss_vld,
    output logic [CODE_W-1:0] iss_code,
    output logic [ROW_W-1:0]  iss_row
);

    logic              vld_q  [GAP];
    logic [CODE_W-1:0] code_q [GAP];
    logic [ROW_W-1:0]  row_q  [GAP];

    genvar g;
    generate
        for (g = 0; g < GAP; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) begin
                        vld_q[g]  <= 1'b0;
                        code_q[g] <= '0;
                        row_q[g]  <= '0;
                    end else begin
                        vld_q[g]  <= name_vld;
                        code_q[g] <= name_code;
                        row_q[g]  <= row;
                    end
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) begin
                        vld_q[g]  <= 1'b0;
                        code_q[g] <= '0;
                        row_q[g]  <= '0;
                    end else begin
                        vld_q[g]  <= vld_q[g-1];
                        code_q[g] <= code_q[g-1];
                        row_q[g]  <= row_q[g-1];
                    end
                end
            end
        end
    endgenerate

    assign iss_vld  = vld_q[GAP-1];
    assign iss_code = code_q[GAP-1];
    assign iss_row  = row_q[GAP-1];

    a_r10_flush_pending: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !iss_vld);

endmodule

// File: rtl/chb_addr_out.sv
module chb_addr_out
    import chb_pkg::*;
#(
    parameter int unsigned ADDR_W = CHB_ADDR_W,
    parameter int unsigned BASE_W = 6,
    parameter int unsigned CODE_W = CHB_CODE_W,
    parameter int unsigned ROW_W  = CHB_ROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_vld,
    input  logic [BASE_W-1:0] base,
    input  logic [CODE_W-1:0] code,
    input  logic [ROW_W-1:0]  row,
    output logic              fetch_vld,
    output logic [ADDR_W-1:0] fetch_addr
);

    logic [ADDR_W-1:0] addr_int;

    // internal address bus, formed in the issue cycle
    assign addr_int = {base, code, row};

    // output latch: address reaches the pins one cycle later
    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_vld  <= 1'b0;
            fetch_addr <= '0;
        end else begin
            fetch_vld <= iss_vld;
            if (iss_vld) begin
                fetch_addr <= addr_int;
            end
        end
    end

    a_r8_hold_addr: assert property (@(posedge clk) disable iff (rst)
        (!fetch_vld && !$past(rst)) |-> $stable(fetch_addr));

endmodule

// File: rtl/chbase_fetch.sv
module chbase_fetch
    import chb_pkg::*;
#(
    parameter int unsigned ADDR_W = CHB_ADDR_W,
    parameter int unsigned DATA_W = CHB_DATA_W,
    parameter int unsigned CODE_W = CHB_CODE_W,
    parameter int unsigned ROW_W  = CHB_ROW_W,
    parameter int unsigned GAP    = CHB_GAP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              name_vld,
    input  logic [DATA_W-1:0] name_code,
    input  logic [ROW_W-1:0]  row,
    output logic              fetch_vld,
    output logic [ADDR_W-1:0] fetch_addr
);

    localparam int unsigned BASE_W = chb_base_w(ADDR_W, CODE_W, ROW_W);
    localparam int unsigned LAT    = chb_out_lat(GAP);

    logic [BASE_W-1:0] base_q;
    logic              iss_vld;
    logic [CODE_W-1:0] iss_code;
    logic [ROW_W-1:0]  iss_row;

    chb_wr_pipe #(
        .DATA_W (DATA_W),
        .BASE_W (BASE_W)
    ) wr_pipe_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .base_q  (base_q)
    );

    chb_fetch_delay #(
        .CODE_W (CODE_W),
        .ROW_W  (ROW_W),
        .GAP    (GAP)
    ) delay_i (
        .clk       (clk),
        .rst       (rst),
        .name_vld  (name_vld),
        .name_code (name_code[CODE_W-1:0]),
        .row       (row),
        .iss_vld   (iss_vld),
        .iss_code  (iss_code),
        .iss_row   (iss_row)
    );

    chb_addr_out #(
        .ADDR_W (ADDR_W),
        .BASE_W (BASE_W),
        .CODE_W (CODE_W),
        .ROW_W  (ROW_W)
    ) out_i (
        .clk        (clk),
        .rst        (rst),
        .iss_vld    (iss_vld),
        .base       (base_q),
        .code       (iss_code),
        .row        (iss_row),
        .fetch_vld  (fetch_vld),
        .fetch_addr (fetch_addr)
    );

    a_r2_issue_spacing: assert property (@(posedge clk) disable iff (rst)
        fetch_vld |-> $past(name_vld, LAT));

    a_r3_code_row_fields: assert property (@(posedge clk) disable iff (rst)
        fetch_vld |-> ((fetch_addr[CODE_W+ROW_W-1:ROW_W] == $past(name_code[CODE_W-1:0], LAT))
                    && (fetch_addr[ROW_W-1:0] == $past(row, LAT))));

endmodule

// File: tb/chbase_fetch_tb.sv
module chbase_fetch_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        name_vld = 1'b0;
    logic [7:0]  name_code = '0;
    logic [2:0]  row = '0;
    logic        fetch_vld;
    logic [15:0] fetch_addr;

    int unsigned n_checks = 0;
    int unsigned n_fail = 0;
    int unsigned t = 8;
    int unsigned since_rst = 0;
    bit          done = 1'b0;

    // history ring, indexed by cycle number modulo 8
    bit          nv_r   [8];
    logic [7:0]  code_r [8];
    logic [2:0]  row_r  [8];
    string       tag_r  [8];
    logic [7:0]  base_r [8];
    logic [7:0]  base_cur = '0;
    logic [15:0] last_a = '0;
    string       rst_tag = "R1";

    chbase_fetch dut_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .name_vld   (name_vld),
        .name_code  (name_code),
        .row        (row),
        .fetch_vld  (fetch_vld),
        .fetch_addr (fetch_addr)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] exp_addr(input logic [7:0] b, input logic [7:0] c,
                                             input logic [2:0] r);
        return {b[7:2], c[6:0], r};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp,
                         input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic clear_hist(input string tag);
        for (int i = 0; i < 8; i++) begin
            nv_r[i] = 1'b0;
            code_r[i] = '0;
            row_r[i] = '0;
            tag_r[i] = tag;
            base_r[i] = '0;
        end
        base_cur = '0;
        last_a = '0;
    endtask

    // one cycle: check outputs of this cycle, then drive this cycle's inputs
    task automatic cyc(input bit r, input bit we, input bit ws, input logic [7:0] wd,
                       input bit nv, input logic [7:0] nc, input logic [2:0] rw,
                       input string tag);
        int unsigned in_n;
        int unsigned ib;
        logic [15:0] ea;
        string       lt;
        @(negedge clk);
        t++;
        in_n = (t - 4) % 8;
        ib = (t - 3) % 8;
        lt = (since_rst < 6) ? rst_tag : "R8";
        if (nv_r[in_n]) begin
            ea = exp_addr(base_r[ib], code_r[in_n], row_r[in_n]);
            check(tag_r[in_n], {15'd0, fetch_vld}, 16'd1, "fetch_vld");
            check(tag_r[in_n], fetch_addr, ea, "fetch_addr");
            last_a = ea;
        end else begin
            check(lt, {15'd0, fetch_vld}, 16'd0, "fetch_vld");
            check(lt, fetch_addr, last_a, "fetch_addr hold");
        end
        rst = r;
        wr_en = we;
        wr_sel = ws;
        wr_data = wd;
        name_vld = nv;
        name_code = nc;
        row = rw;
        if (r) begin
            clear_hist(tag);
            rst_tag = tag;
            since_rst = 0;
        end else begin
            since_rst++;
            if (we && ws) base_cur = wd;
            base_r[t % 8] = base_cur;
            nv_r[t % 8] = nv;
            code_r[t % 8] = nc;
            row_r[t % 8] = rw;
            tag_r[t % 8] = (nc[7] && nv) ? "R4" : tag;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00, 0, 8'h00, 3'd0, "R3");
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        clear_hist("R1");
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 8'h00, 0, 8'h00, 3'd0, "R1");
        idle(4);
        // R1: first fetch after reset uses base zero
        cyc(0, 0, 0, 8'h00, 1, 8'h11, 3'd5, "R1");
        idle(5);
        // R7 and R6: base 0x60, late write 0x80, then in-time write 0xA0
        cyc(0, 1, 1, 8'h60, 0, 8'h00, 3'd0, "R3");
        idle(3);
        cyc(0, 0, 0, 8'h00, 1, 8'h05, 3'd2, "R7");
        idle(1);
        cyc(0, 1, 1, 8'h80, 0, 8'h00, 3'd0, "R7");
        idle(4);
        cyc(0, 1, 1, 8'h60, 0, 8'h00, 3'd0, "R3");
        idle(3);
        cyc(0, 0, 0, 8'h00, 1, 8'h06, 3'd3, "R6");
        cyc(0, 1, 1, 8'hA0, 0, 8'h00, 3'd0, "R6");
        idle(5);
        // R5: write cycle without select
        cyc(0, 1, 0, 8'hFC, 0, 8'h00, 3'd0, "R5");
        idle(2);
        cyc(0, 0, 0, 8'h00, 1, 8'h2A, 3'd7, "R5");
        idle(5);
        // R4: code bit 7 set
        cyc(0, 0, 0, 8'h00, 1, 8'hFF, 3'd1, "R4");
        idle(5);
        // R9: back-to-back name fetches
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 8'h00, 1, 8'(i * 13 + 3), 3'(i), "R9");
        idle(6);
        // R10: reset with three fetches pending
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 8'h00, 1, 8'(i + 40), 3'(i), "R10");
        cyc(1, 0, 0, 8'h00, 0, 8'h00, 3'd0, "R10");
        idle(6);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            cyc(0, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                8'($urandom), bit'($urandom_range(0, 1)), 8'($urandom),
                3'($urandom), "R3");
        end
        idle(6);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule